// File: doc/BRIEF.md
# Quasi-Resonant Turn-On Trigger

This block decides the moment at which a quasi-resonant flyback controller closes its power switch. It watches two digitized comparator flags taken from the demagnetization sense pin: a high-level flag that arms the trigger and a low-level flag whose falling edge marks a ringing valley. After every turn-off it opens a blanking window. The length of the window comes from a quantized code of the loop control voltage, so a light load gives a long window. Falling edges that land inside the window are ignored, which is how ringing valleys get skipped. A valid edge is followed by a short fixed delay, so the switch closes near the voltage minimum.

A separate ceiling holds back any early turn-on so that the switching frequency stays bounded. When no valid edge arrives, a free-running starter issues the request instead. This covers power-up, and it also covers constant-current operation, where the output voltage is too low to arm the trigger. The starter runs slowly while the control voltage is below the burst threshold and faster above it, and its timer restarts on every turn-on.

The controller is a state machine with five states:
- `ST_OFF`: disabled.
- `ST_ON`: the switch is on and the block waits for the turn-off event.
- `ST_BLANK`: the blanking count is running.
- `ST_HUNT`: the window has expired and the block waits for an armed falling edge.
- `ST_DELAY`: the valley delay, which is also held by the ceiling.

Transitions:
- Any state goes to `ST_OFF` when enable is low.
- `ST_OFF` goes to `ST_HUNT` once enable is high.
- `ST_ON` goes to `ST_BLANK` on `sw_off`.
- `ST_BLANK` goes to `ST_HUNT` when the count ends.
- `ST_HUNT` goes to `ST_DELAY` on an armed falling edge.
- Any enabled state goes to `ST_ON` when a turn-on fires. From `ST_DELAY` this happens when the delay is done and the ceiling allows it. From every other enabled state it happens when the starter is due.

Top module: `qr_turnon_trigger`

## Requirements
- R1: While `enable` is low, `turn_on` stays 0, the arm flag is cleared and the starter timer is held at zero. The first starter request after `enable` is driven high in cycle k appears in cycle k+STARTER_SLOW, provided `ctrl_above_burst` is 0. After reset `turn_on` is 0.
- R2: A falling edge of `sense_trig` (1 in one cycle, 0 in the next) has no effect unless `sense_arm` was seen at 1 since the last turn-off.
- R3: A falling edge is qualified when it is armed and presented in cycle k while the block waits in `ST_HUNT`. A qualified edge gives a single `turn_on` pulse in cycle k+VALLEY_DLY+1, unless R6 postpones it.
- R4: Let `sw_off` be pulsed in cycle s, with blanking length L. A falling edge presented in any cycle up to and including s+L is ignored. An edge presented in cycle s+L+1 is accepted.
- R5: The blanking length is L = BLANK_MAX − code·(BLANK_MAX−BLANK_MIN)/(2^CODE_W−1), using integer division. Code 0 therefore gives the longest window. `blank_sel` is sampled in the cycle of `sw_off`, and later changes do not alter the running window.
- R6: Two `turn_on` pulses are never closer than MIN_PERIOD cycles. A qualified turn-on that would come earlier is issued exactly MIN_PERIOD cycles after the previous pulse.
- R7: If no turn-on happens for P cycles, the starter issues one. P is STARTER_SLOW when `ctrl_above_burst` is 0 and STARTER_FAST when it is 1. The starter timer restarts on every turn-on from either source.
- R8: The arm flag clears on every turn-on. An arming seen before a starter turn-on does not qualify an edge after it.
- R9: `turn_on` is a pulse one clock cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Global enable; low forces the block idle |
| sense_arm | input | 1 | Sense pin above the upper (arming) level |
| sense_trig | input | 1 | Sense pin above the lower (trigger) level |
| ctrl_above_burst | input | 1 | Control voltage above the burst threshold |
| blank_sel | input | CODE_W | Quantized control-voltage code for the blanking length |
| sw_off | input | 1 | One-cycle turn-off event from the PWM path |
| turn_on | output | 1 | One-cycle turn-on request |

## Verification
The bench uses CODE_W=2, BLANK_MAX=40 and BLANK_MIN=10, which give window lengths of 40, 30, 20 and 10 cycles. It also uses MIN_PERIOD=24, VALLEY_DLY=3, STARTER_SLOW=200 and STARTER_FAST=60. The 10-cycle window is shorter than the ceiling, so a qualified edge collides with the frequency limit. Both starter rates and the exact one-cycle boundary of each window can be reached in a few hundred cycles per case. An ignored edge shows up at the port as the absence of a pulse: the next request is the starter's, at a time computed in advance.

// File: rtl/qrt_pkg.sv
package qrt_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_ON,
        ST_BLANK,
        ST_HUNT,
        ST_DELAY
    } qrt_state_e;

    // Blanking length for one control-voltage code: longest at code 0,
    // falling linearly to the shortest at the top code.
    function automatic int unsigned blank_len(input int unsigned code,
                                              input int unsigned n_codes,
                                              input int unsigned lmax,
                                              input int unsigned lmin);
        if (n_codes < 2)
            return lmax;
        return lmax - (code * (lmax - lmin)) / (n_codes - 1);
    endfunction

endpackage

// File: rtl/qrt_blank_lut.sv
module qrt_blank_lut #(
    parameter int CODE_W    = 3,
    parameter int BLANK_MAX = 1500,
    parameter int BLANK_MIN = 300,
    parameter int LEN_W     = $clog2(BLANK_MAX + 1)
) (
    input  logic [CODE_W-1:0] code,
    output logic [LEN_W-1:0]  len
);
    localparam int NCODE = 1 << CODE_W;

    logic [LEN_W-1:0] tab [NCODE];

    for (genvar g = 0; g < NCODE; g++) begin : g_entry
        assign tab[g] = LEN_W'(qrt_pkg::blank_len(g, NCODE, BLANK_MAX, BLANK_MIN));
    end

    assign len = tab[code];
endmodule

// File: rtl/qrt_arm_edge.sv
module qrt_arm_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic set_ok,
    input  logic sense_arm,
    input  logic sense_trig,
    output logic armed,
    output logic fall
);
    logic trig_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_q <= 1'b0;
            armed  <= 1'b0;
        end else begin
            trig_q <= sense_trig;
            if (clr)
                armed <= 1'b0;
            else if (set_ok && sense_arm)
                armed <= 1'b1;
        end
    end

    assign fall = trig_q & ~sense_trig;
endmodule

// File: rtl/qrt_starter.sv
module qrt_starter #(
    parameter int STARTER_SLOW = 25000,
    parameter int STARTER_FAST = 6250,
    parameter int MIN_PERIOD   = 302,
    parameter int CNT_W        = $clog2(STARTER_SLOW + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic restart,
    input  logic fast,
    output logic due,
    output logic ceil_ok
);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] LIM_SLOW = CNT_W'(STARTER_SLOW - 1);
    localparam logic [CNT_W-1:0] LIM_FAST = CNT_W'(STARTER_FAST - 1);
    localparam logic [CNT_W-1:0] LIM_MIN  = CNT_W'(MIN_PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!enable || restart)
            cnt_q <= '0;
        else if (cnt_q != CNT_MAX)
            cnt_q <= cnt_q + 1'b1;
    end

    assign due     = cnt_q >= (fast ? LIM_FAST : LIM_SLOW);
    assign ceil_ok = cnt_q >= LIM_MIN;
endmodule

// File: rtl/qr_turnon_trigger.sv
module qr_turnon_trigger #(
    parameter int CODE_W       = 3,
    parameter int BLANK_MAX    = 1500,
    parameter int BLANK_MIN    = 300,
    parameter int MIN_PERIOD   = 302,
    parameter int VALLEY_DLY   = 8,
    parameter int STARTER_SLOW = 25000,
    parameter int STARTER_FAST = 6250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              sense_arm,
    input  logic              sense_trig,
    input  logic              ctrl_above_burst,
    input  logic [CODE_W-1:0] blank_sel,
    input  logic              sw_off,
    output logic              turn_on
);
    import qrt_pkg::*;

    localparam int LEN_W = $clog2(BLANK_MAX + 1);
    localparam int DLY_W = $clog2(VALLEY_DLY + 1);
    localparam int CNT_W = $clog2(STARTER_SLOW + 1);

    qrt_state_e       state_q, state_d;
    logic [LEN_W-1:0] bcnt_q;
    logic [DLY_W-1:0] dcnt_q;
    logic [LEN_W-1:0] blank_now;
    logic             armed, fall, due, ceil_ok, fire;

    qrt_blank_lut #(
        .CODE_W(CODE_W), .BLANK_MAX(BLANK_MAX), .BLANK_MIN(BLANK_MIN), .LEN_W(LEN_W)
    ) u_lut (
        .code(blank_sel), .len(blank_now)
    );

    qrt_arm_edge u_edge (
        .clk(clk), .rst_n(rst_n),
        .clr(fire || !enable),
        .set_ok(state_q == ST_BLANK || state_q == ST_HUNT),
        .sense_arm(sense_arm), .sense_trig(sense_trig),
        .armed(armed), .fall(fall)
    );

    qrt_starter #(
        .STARTER_SLOW(STARTER_SLOW), .STARTER_FAST(STARTER_FAST),
        .MIN_PERIOD(MIN_PERIOD), .CNT_W(CNT_W)
    ) u_start (
        .clk(clk), .rst_n(rst_n), .enable(enable), .restart(fire),
        .fast(ctrl_above_burst), .due(due), .ceil_ok(ceil_ok)
    );

    // Turn-on decision: valley path out of the delay, starter elsewhere.
    always_comb begin
        fire = 1'b0;
        if (enable) begin
            if (state_q == ST_DELAY)
                fire = (dcnt_q == DLY_W'(1)) && ceil_ok;
            else if (state_q != ST_OFF)
                fire = due;
        end
    end

    always_comb begin
        state_d = state_q;
        if (!enable)
            state_d = ST_OFF;
        else if (fire)
            state_d = ST_ON;
        else begin
            unique case (state_q)
                ST_OFF:   state_d = ST_HUNT;
                ST_ON:    if (sw_off) state_d = ST_BLANK;
                ST_BLANK: if (bcnt_q == LEN_W'(1)) state_d = ST_HUNT;
                ST_HUNT:  if (armed && fall) state_d = ST_DELAY;
                ST_DELAY: state_d = ST_DELAY;
            endcase
        end
    end

    // State register with its blanking and valley-delay counters.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            bcnt_q  <= '0;
            dcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_ON && state_d == ST_BLANK)
                bcnt_q <= blank_now;
            else if (state_q == ST_BLANK && bcnt_q > LEN_W'(1))
                bcnt_q <= bcnt_q - 1'b1;
            if (state_q != ST_DELAY && state_d == ST_DELAY)
                dcnt_q <= DLY_W'(VALLEY_DLY);
            else if (state_q == ST_DELAY && dcnt_q > DLY_W'(1))
                dcnt_q <= dcnt_q - 1'b1;
        end
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            turn_on <= 1'b0;
        else
            turn_on <= fire;
    end
endmodule

// File: rtl/qrt_trigger_chk.sv
module qrt_trigger_chk #(
    parameter int MIN_PERIOD = 302
) (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic turn_on,
    input logic armed
);
    int unsigned gap_q;
    logic        seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= 0;
            seen_q <= 1'b0;
        end else if (turn_on) begin
            gap_q  <= 0;
            seen_q <= 1'b1;
        end else if (gap_q != 32'hFFFF_FFFF) begin
            gap_q <= gap_q + 1;
        end
    end

    // R1
    no_turnon_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !turn_on);

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        turn_on |=> !turn_on);

    // R6
    min_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (turn_on && seen_q) |-> (gap_q >= MIN_PERIOD - 1));

    // R8
    arm_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        turn_on |-> !armed);
endmodule

bind qr_turnon_trigger qrt_trigger_chk #(.MIN_PERIOD(MIN_PERIOD)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .turn_on(turn_on), .armed(armed)
);

// File: tb/tb_qr_turnon_trigger.sv
module tb_qr_turnon_trigger;
    localparam int CODE_W = 2;
    localparam int BMAX   = 40;
    localparam int BMIN   = 10;
    localparam int MINP   = 24;
    localparam int DLY    = 3;
    localparam int SLOW   = 200;
    localparam int FAST   = 60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, sense_arm = 1'b0, sense_trig = 1'b0;
    logic ctrl_above_burst = 1'b0, sw_off = 1'b0;
    logic [CODE_W-1:0] blank_sel = '0;
    logic turn_on;

    qr_turnon_trigger #(
        .CODE_W(CODE_W), .BLANK_MAX(BMAX), .BLANK_MIN(BMIN), .MIN_PERIOD(MINP),
        .VALLEY_DLY(DLY), .STARTER_SLOW(SLOW), .STARTER_FAST(FAST)
    ) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .sense_arm(sense_arm),
        .sense_trig(sense_trig), .ctrl_above_burst(ctrl_above_burst),
        .blank_sel(blank_sel), .sw_off(sw_off), .turn_on(turn_on)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int    checks = 0, errors = 0, last_on = 0;
    bit    prev_on = 0, done = 0;
    int    exp_q[$];
    string tag_q[$];

    function automatic int blen(int code);
        return BMAX - (code * (BMAX - BMIN)) / ((1 << CODE_W) - 1);
    endfunction

    task automatic expect_at(int c, string tag);
        exp_q.push_back(c);
        tag_q.push_back(tag);
    endtask

    // Monitor: pops expected pulse cycles and compares.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (prev_on) begin
                checks++;
                if (turn_on) begin
                    errors++;
                    $display("FAIL R9: pulse width actual>=2 expected 1 at cycle %0d", cyc);
                end
            end
            if (turn_on) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL unexpected turn_on: actual cycle %0d expected none", cyc);
                end else begin
                    int    e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (e != cyc) begin
                        errors++;
                        $display("FAIL %s: turn_on actual cycle %0d expected %0d", t, cyc, e);
                    end
                end
                last_on = cyc;
            end
            prev_on = turn_on;
        end
    end

    task automatic await_all();
        int n = 0;
        while (exp_q.size() != 0 && n < 1000) begin
            @(negedge clk);
            n++;
        end
        if (exp_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL %s: turn_on actual none expected cycle %0d", tag_q[0], exp_q[0]);
            exp_q.delete();
            tag_q.delete();
        end
        @(negedge clk);
    endtask

    // Turn-off, optional arming, then a falling edge at s+L+off.
    task automatic edge_case(int code, int off, bit do_arm, bit accept, string tag);
        int s, k, e;
        @(negedge clk);
        s = cyc;
        blank_sel = code[CODE_W-1:0];
        sw_off = 1'b1;
        @(negedge clk);
        sw_off = 1'b0;
        blank_sel = '1; // R5: later code change must not matter
        sense_trig = 1'b1;
        sense_arm = do_arm;
        @(negedge clk);
        sense_arm = 1'b0;
        k = s + blen(code) + off;
        while (cyc < k) @(negedge clk);
        sense_trig = 1'b0;
        if (accept) begin
            e = k + DLY + 1;
            if (last_on + MINP > e) e = last_on + MINP;
        end else begin
            e = last_on + SLOW;
        end
        expect_at(e, tag);
        await_all();
    endtask

    initial begin
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (turn_on !== 1'b0) begin
            errors++;
            $display("FAIL R1: reset turn_on actual %b expected 0", turn_on);
        end

        // R1 / R7: starter from enable, then a second slow period
        @(negedge clk);
        enable = 1'b1;
        k = cyc;
        expect_at(k + SLOW, "R1");
        await_all();
        expect_at(last_on + SLOW, "R7");
        await_all();

        // R7: fast starter above burst threshold
        ctrl_above_burst = 1'b1;
        expect_at(last_on + FAST, "R7");
        await_all();
        ctrl_above_burst = 1'b0;

        // R3 / R5: code 0, edge just after window
        edge_case(0, 1, 1'b1, 1'b1, "R3");
        // R6: shortest window, ceiling postpones
        edge_case(3, 1, 1'b1, 1'b1, "R6");
        // R4: code 1 boundary, last blanked cycle then first open cycle
        edge_case(1, 0, 1'b1, 1'b0, "R4");
        edge_case(1, 1, 1'b1, 1'b1, "R4");
        // R5: code 2 accepted at its edge, code 0 blanked at s+40
        edge_case(2, 1, 1'b1, 1'b1, "R5");
        edge_case(0, 0, 1'b1, 1'b0, "R5");
        // R2: no arming
        edge_case(0, 1, 1'b0, 1'b0, "R2");

        // R8: arm, starter turn-on intervenes, unarmed edge ignored
        @(negedge clk);
        blank_sel = '0;
        sw_off = 1'b1;
        @(negedge clk);
        sw_off = 1'b0;
        sense_trig = 1'b1;
        sense_arm = 1'b1;
        @(negedge clk);
        sense_arm = 1'b0;
        expect_at(last_on + SLOW, "R8");
        await_all();
        edge_case(0, 1, 1'b0, 1'b0, "R8");

        // R1: disabled window shows nothing, then restart from enable
        @(negedge clk);
        enable = 1'b0;
        begin
            bit bad = 0;
            for (int i = 0; i < 300; i++) begin
                @(negedge clk);
                if (turn_on) bad = 1;
            end
            checks++;
            if (bad) begin
                errors++;
                $display("FAIL R1: disabled turn_on actual 1 expected 0");
            end
        end
        enable = 1'b1;
        k = cyc;
        expect_at(k + SLOW, "R1");
        await_all();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule